// File: doc/BRIEF.md
# DMA Access Unit with Bus-Error Lockout

The unit sits between a DMA channel scheduler and the system bus. It accepts one access request at a time, tagged with one of up to sixteen virtual channel numbers, and turns it into one bus transaction. A transaction is a single byte, half-word or word beat, or a burst of four word beats. Each beat carries the requesting channel's 3-bit function code on the bus, so the rest of the system can see which channel is accessing memory. The channel's byte-ordering mode is applied on the way: big-endian passes everything through, true little-endian reverses the bytes within the access width, and munged little-endian changes the low address bits instead of the data.

Requests arrive on a valid/ready stream. A request moves only in a cycle where `req_valid` and `req_ready` are both high, and the fields must hold while `req_valid` is high. One response per beat leaves on a second valid/ready stream. While `rsp_ready` is low, the response and its data hold and no further beat is issued. The bus side is a held-request interface: a beat stays on the bus, unchanged, until `bus_ready` or `bus_err` is seen.

A bus error ends the transaction at once. The unit records the failing beat's bus address, sets a sticky error flag that can raise an interrupt, and stops taking requests. Only a `reset_cmd` pulse brings it back into service.

Top module: `dma_access_unit`

## Requirements
- R1: During every beat, `bus_fc` equals the function code that was programmed through `cfg_*` for the request's channel, as it stood when the request was accepted.
- R2: With order code 2'b00 (big-endian), the bus address is the request address, write data go out unchanged, and read data return unchanged.
- R3: With order code 2'b01 (true little-endian), data bytes are reversed within the access width, for both write data and read data. A byte access is unchanged. A half-word access swaps bits [7:0] with bits [15:8] and leaves bits [31:16] alone. A word or burst beat reverses all four bytes. The address is not changed.
- R4: With order code 2'b10 (munged little-endian), address bits [2:0] are XORed with 3'b111 for a byte, 3'b110 for a half-word, and 3'b100 for a word or burst beat. Data pass unchanged.
- R5: Size codes are 2'b00 byte, 2'b01 half-word, 2'b10 word and 2'b11 burst. A burst issues four beats at request address +0, +4, +8 and +12 (before any munging). Each beat produces one response, `rsp_last` is set only on the final one, and no new request is accepted until the transaction ends.
- R6: A response holds `rsp_valid` and `rsp_data` until `rsp_ready`, and no beat is issued in the meantime. A bus beat holds its address, code and data until `bus_ready` or `bus_err`.
- R7: A beat that ends with `bus_err` sets `err_flag` and `halted`. It produces a response with `rsp_err` and `rsp_last` both set, and the remaining burst beats are not issued.
- R8: `err_addr` captures the bus address of the failing beat.
- R9: While `halted` is high, `req_ready` is low and no beat is issued. A `reset_cmd` pulse clears `halted`.
- R10: `err_flag` is cleared by an `err_clr` pulse (write-one-to-clear), and a new error in the same cycle wins. `irq` is high exactly when `err_flag` and `irq_mask` are both high. Clearing the flag does not release the halt.
- R11: After reset, `req_ready` is high, while `bus_valid`, `rsp_valid`, `err_flag`, `irq` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for per-channel settings |
| cfg_chan | input | 4 | Channel being configured |
| cfg_fc | input | 3 | Function code for that channel |
| cfg_order | input | 2 | Byte-order code for that channel |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_chan | input | 4 | Requesting channel |
| req_addr | input | 32 | Start address |
| req_size | input | 2 | Size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified, used on every burst beat |
| rsp_valid | output | 1 | Per-beat response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Read data after ordering (zero for writes) |
| rsp_last | output | 1 | Final response of the transaction |
| rsp_err | output | 1 | Beat ended in a bus error |
| bus_valid | output | 1 | Beat on the bus |
| bus_ready | input | 1 | Beat completed |
| bus_err | input | 1 | Beat failed |
| bus_addr | output | 32 | Beat address |
| bus_fc | output | 3 | Function code of the channel |
| bus_write | output | 1 | Beat direction |
| bus_size | output | 2 | Beat size code (burst beats report word) |
| bus_wdata | output | 32 | Beat write data |
| bus_rdata | input | 32 | Beat read data |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| reset_cmd | input | 1 | Global command that leaves the halted state |
| irq_mask | input | 1 | Interrupt enable |
| err_flag | output | 1 | Sticky bus-error status |
| err_addr | output | 32 | Address of the failing beat |
| irq | output | 1 | Interrupt |
| halted | output | 1 | Engine locked after an error |

## Verification
A beat is on the bus in the cycle after its request is accepted. Its response is valid in the cycle after `bus_ready`. The next burst beat appears in the cycle after that response is taken. `err_flag`, `err_addr`, `halted` and `irq` change in the cycle after the edge that sees `bus_err`. The bench drives all inputs on the falling clock edge. A bus model records every beat at the falling edge where the beat is first visible, and answers for the next rising edge. A monitor records responses between edges. Each check waits an exact number of falling edges, counted from these latencies, before it samples.

// File: rtl/dau_pkg.sv
package dau_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_BURST = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ORD_BIG    = 2'b00,
    ORD_TRUELE = 2'b01,
    ORD_MUNGED = 2'b10,
    ORD_RSVD   = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BEAT = 2'b01,
    ST_RESP = 2'b10
  } state_e;

  typedef struct packed {
    logic [2:0] fc;
    order_e     order;
  } chan_cfg_t;

  localparam int BURST_BEATS = 4;
endpackage

// File: rtl/dau_chan_cfg.sv
module dau_chan_cfg
  import dau_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic [2:0]    wr_fc,
  input  logic [1:0]    wr_order,
  input  logic [CW-1:0] rd_chan,
  output chan_cfg_t     rd_cfg
);
  chan_cfg_t slots [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '{fc: 3'd0, order: ORD_BIG};
      end else if (wr_en && wr_chan == CW'(g)) begin
        slots[g] <= '{fc: wr_fc, order: order_e'(wr_order)};
      end
    end
  end

  assign rd_cfg = slots[rd_chan];
endmodule

// File: rtl/dau_byte_rev.sv
module dau_byte_rev
  import dau_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          en,
  input  logic [1:0]    size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb begin
    dout = din;
    if (en) begin
      unique case (size_e'(size))
        SZ_BYTE: dout = din;
        SZ_HALF: begin
          dout[7:0]  = din[15:8];
          dout[15:8] = din[7:0];
        end
        default: begin
          for (int i = 0; i < NB; i++) dout[8*i +: 8] = din[8*(NB-1-i) +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/dau_err_status.sv
module dau_err_status #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_evt,
  input  logic [AW-1:0] err_evt_addr,
  input  logic          err_clr,
  input  logic          reset_cmd,
  input  logic          irq_mask,
  output logic          err_flag,
  output logic [AW-1:0] err_addr,
  output logic          halted,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
      halted   <= 1'b0;
    end else begin
      if (err_evt) begin
        err_flag <= 1'b1;
        err_addr <= err_evt_addr;
        halted   <= 1'b1;
      end else begin
        if (err_clr)   err_flag <= 1'b0;
        if (reset_cmd) halted   <= 1'b0;
      end
    end
  end

  assign irq = err_flag & irq_mask;
endmodule

// File: rtl/dma_access_unit.sv
module dma_access_unit
  import dau_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int CW = $clog2(NCH),
  localparam int BW = $clog2(BURST_BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_chan,
  input  logic [2:0]    cfg_fc,
  input  logic [1:0]    cfg_order,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_chan,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last,
  output logic          rsp_err,
  output logic          bus_valid,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_fc,
  output logic          bus_write,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          err_clr,
  input  logic          reset_cmd,
  input  logic          irq_mask,
  output logic          err_flag,
  output logic [AW-1:0] err_addr,
  output logic          irq,
  output logic          halted
);
  state_e        st;
  chan_cfg_t     sel_cfg, cur_cfg;
  logic [AW-1:0] cur_addr;
  size_e         cur_size;
  logic          cur_we;
  logic [DW-1:0] cur_wdata;
  logic [BW-1:0] beat;
  logic [DW-1:0] rsp_data_q;
  logic          rsp_last_q, rsp_err_q;
  logic [AW-1:0] beat_addr;
  logic [2:0]    munge_k;
  logic          swap_en, last_beat, err_evt;
  logic [DW-1:0] rd_ordered;

  dau_chan_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_chan(cfg_chan),
    .wr_fc(cfg_fc), .wr_order(cfg_order), .rd_chan(req_chan), .rd_cfg(sel_cfg)
  );

  assign swap_en   = (cur_cfg.order == ORD_TRUELE);
  assign last_beat = (cur_size != SZ_BURST) || (beat == BW'(BURST_BEATS - 1));
  assign beat_addr = cur_addr + {{(AW-BW-2){1'b0}}, beat, 2'b00};

  always_comb begin
    unique case (cur_size)
      SZ_BYTE: munge_k = 3'b111;
      SZ_HALF: munge_k = 3'b110;
      default: munge_k = 3'b100;
    endcase
  end

  assign bus_addr  = (cur_cfg.order == ORD_MUNGED) ?
                     (beat_addr ^ {{(AW-3){1'b0}}, munge_k}) : beat_addr;
  assign bus_valid = (st == ST_BEAT);
  assign bus_fc    = cur_cfg.fc;
  assign bus_write = cur_we;
  assign bus_size  = (cur_size == SZ_BURST) ? SZ_WORD : cur_size;

  dau_byte_rev #(.DW(DW)) u_wr_rev (
    .en(swap_en), .size(cur_size), .din(cur_wdata), .dout(bus_wdata)
  );
  dau_byte_rev #(.DW(DW)) u_rd_rev (
    .en(swap_en), .size(cur_size), .din(bus_rdata), .dout(rd_ordered)
  );

  assign err_evt   = (st == ST_BEAT) && bus_err;
  assign req_ready = (st == ST_IDLE) && !halted;
  assign rsp_valid = (st == ST_RESP);
  assign rsp_data  = rsp_data_q;
  assign rsp_last  = rsp_last_q;
  assign rsp_err   = rsp_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_cfg    <= '{fc: 3'd0, order: ORD_BIG};
      cur_addr   <= '0;
      cur_size   <= SZ_BYTE;
      cur_we     <= 1'b0;
      cur_wdata  <= '0;
      beat       <= '0;
      rsp_data_q <= '0;
      rsp_last_q <= 1'b0;
      rsp_err_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          cur_cfg   <= sel_cfg;
          cur_addr  <= req_addr;
          cur_size  <= size_e'(req_size);
          cur_we    <= req_write;
          cur_wdata <= req_wdata;
          beat      <= '0;
          st        <= ST_BEAT;
        end
        ST_BEAT: if (bus_err) begin
          rsp_data_q <= '0;
          rsp_last_q <= 1'b1;
          rsp_err_q  <= 1'b1;
          st         <= ST_RESP;
        end else if (bus_ready) begin
          rsp_data_q <= cur_we ? '0 : rd_ordered;
          rsp_last_q <= last_beat;
          rsp_err_q  <= 1'b0;
          st         <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) begin
          if (rsp_last_q || rsp_err_q) begin
            st <= ST_IDLE;
          end else begin
            beat <= beat + 1'b1;
            st   <= ST_BEAT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  dau_err_status #(.AW(AW)) u_err (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_evt_addr(bus_addr),
    .err_clr(err_clr), .reset_cmd(reset_cmd), .irq_mask(irq_mask),
    .err_flag(err_flag), .err_addr(err_addr), .halted(halted), .irq(irq)
  );
endmodule

// File: rtl/dau_checker.sv
module dau_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_fc,
  input logic          err_flag,
  input logic [AW-1:0] err_addr,
  input logic          halted
);
  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !bus_err |=> bus_valid && $stable(bus_addr) && $stable(bus_fc));

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_one_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && rsp_valid));

  assert_err_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_err |=> err_flag && halted && rsp_valid);

  assert_err_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_err |=> err_addr == $past(bus_addr));

  assert_halt_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !req_ready);
endmodule

bind dma_access_unit dau_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_err(bus_err), .bus_addr(bus_addr), .bus_fc(bus_fc),
  .err_flag(err_flag), .err_addr(err_addr), .halted(halted)
);

// File: tb/dma_access_unit_bench.sv
module dma_access_unit_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cfg_we = 0; logic [3:0] cfg_chan = 0; logic [2:0] cfg_fc = 0; logic [1:0] cfg_order = 0;
  logic req_valid = 0, req_ready; logic [3:0] req_chan = 0; logic [31:0] req_addr = 0;
  logic [1:0] req_size = 0; logic req_write = 0; logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_ready = 1, rsp_last, rsp_err; logic [31:0] rsp_data;
  logic bus_valid, bus_ready = 0, bus_err = 0, bus_write; logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = 0; logic [2:0] bus_fc; logic [1:0] bus_size;
  logic err_clr = 0, reset_cmd = 0, irq_mask = 0, err_flag, irq, halted; logic [31:0] err_addr;

  dma_access_unit u_dma_access_unit (.*);

  int n_chk = 0, n_fail = 0;
  int nb = 0, nr = 0, err_beat = -1;
  logic [31:0] lg_addr [8], lg_wdata [8], rs_data [8];
  logic [2:0]  lg_fc [8];
  logic        rs_last [8], rs_err [8];

  // bus model: records a beat at the falling edge it is seen, answers for the next rising edge
  always @(negedge clk) begin
    #1;
    bus_ready = 0; bus_err = 0;
    if (bus_valid) begin
      if (nb < 8) begin lg_addr[nb] = bus_addr; lg_wdata[nb] = bus_wdata; lg_fc[nb] = bus_fc; end
      bus_rdata = 32'hA1B2C3D0 + nb;
      if (nb == err_beat) bus_err = 1; else bus_ready = 1;
      nb++;
    end
  end

  // response monitor, between edges
  always @(negedge clk) begin
    #2;
    if (rsp_valid && rsp_ready && nr < 8) begin
      rs_data[nr] = rsp_data; rs_last[nr] = rsp_last; rs_err[nr] = rsp_err; nr++;
    end else if (rsp_valid && rsp_ready) nr++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic configure(input logic [3:0] ch, input logic [2:0] fc, input logic [1:0] ord);
    @(negedge clk); cfg_we = 1; cfg_chan = ch; cfg_fc = fc; cfg_order = ord;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run_txn(input logic [3:0] ch, input logic [31:0] a, input logic [1:0] sz,
                         input logic we, input logic [31:0] wd, input int wait_cyc);
    @(negedge clk);
    nb = 0; nr = 0;
    req_valid = 1; req_chan = ch; req_addr = a; req_size = sz; req_write = we; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 req_ready", req_ready, 1); chk("R11 bus_valid", bus_valid, 0);
    chk("R11 rsp_valid", rsp_valid, 0); chk("R11 err_flag", err_flag, 0);
    chk("R11 irq", irq, 0); chk("R11 halted", halted, 0);
  endtask

  task automatic t_big();
    configure(4'd3, 3'd5, 2'b00);
    run_txn(4'd3, 32'h1000, 2'b10, 1, 32'hCAFEBABE, 4);
    chk("R1 fc", lg_fc[0], 5); chk("R2 addr", lg_addr[0], 32'h1000);
    chk("R2 wdata", lg_wdata[0], 32'hCAFEBABE); chk("R5 one rsp", nr, 1);
    chk("R5 last", rs_last[0], 1);
    run_txn(4'd3, 32'h1010, 2'b10, 0, 0, 4);
    chk("R2 rdata", rs_data[0], 32'hA1B2C3D0);
  endtask

  task automatic t_true_le();
    configure(4'd7, 3'd2, 2'b01);
    run_txn(4'd7, 32'h2002, 2'b01, 1, 32'h55661234, 4);
    chk("R3 half wdata", lg_wdata[0], 32'h55663412); chk("R3 addr", lg_addr[0], 32'h2002);
    chk("R1 fc ch7", lg_fc[0], 2);
    run_txn(4'd7, 32'h2004, 2'b10, 0, 0, 4);
    chk("R3 word rdata", rs_data[0], 32'hD0C3B2A1);
    run_txn(4'd7, 32'h2001, 2'b00, 1, 32'h000000AB, 4);
    chk("R3 byte wdata", lg_wdata[0], 32'h000000AB);
  endtask

  task automatic t_munged();
    configure(4'd9, 3'd6, 2'b10);
    run_txn(4'd9, 32'h100, 2'b00, 1, 32'h11, 4);
    chk("R4 byte addr", lg_addr[0], 32'h107); chk("R4 byte data", lg_wdata[0], 32'h11);
    run_txn(4'd9, 32'h102, 2'b01, 0, 0, 4);
    chk("R4 half addr", lg_addr[0], 32'h104); chk("R4 half rdata", rs_data[0], 32'hA1B2C3D0);
    run_txn(4'd9, 32'h108, 2'b10, 1, 32'h0BADF00D, 4);
    chk("R4 word addr", lg_addr[0], 32'h10C); chk("R4 word data", lg_wdata[0], 32'h0BADF00D);
  endtask

  task automatic t_burst();
    configure(4'd0, 3'd1, 2'b00);
    run_txn(4'd0, 32'h3000, 2'b11, 0, 0, 10);
    chk("R5 beats", nb, 4); chk("R5 rsps", nr, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 beat addr", lg_addr[i], 32'h3000 + 4 * i);
      chk("R1 burst fc", lg_fc[i], 1);
      chk("R5 beat data", rs_data[i], 32'hA1B2C3D0 + i);
      chk("R5 last flag", rs_last[i], (i == 3));
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    rsp_ready = 0;
    run_txn(4'd0, 32'h3100, 2'b11, 0, 0, 4);
    held = rsp_data;
    chk("R6 rsp held", rsp_valid, 1); chk("R6 no beat", bus_valid, 0);
    chk("R6 one beat", nb, 1); chk("R6 none taken", nr, 0);
    chk("R6 data stable", held, 32'hA1B2C3D0);
    rsp_ready = 1;
    repeat (10) @(negedge clk);
    chk("R6 burst resumes", nb, 4); chk("R6 all rsps", nr, 4);
  endtask

  task automatic t_error();
    irq_mask = 1; err_beat = 1;
    @(negedge clk);
    nb = 0; nr = 0;
    req_valid = 1; req_chan = 4'd3; req_addr = 32'h4000; req_size = 2'b11;
    req_write = 1; req_wdata = 32'h12345678;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (nb < 2) @(negedge clk);
    @(negedge clk);
    chk("R7 flag due", err_flag, 1); chk("R8 err addr", err_addr, 32'h4004);
    chk("R7 halted", halted, 1); chk("R10 irq", irq, 1);
    repeat (8) @(negedge clk);
    err_beat = -1;
    chk("R7 no more beats", nb, 2); chk("R7 rsps", nr, 2);
    chk("R7 rsp err", rs_err[1], 1); chk("R7 rsp last", rs_last[1], 1);
    chk("R9 req_ready low", req_ready, 0);
  endtask

  task automatic t_halted_ignores();
    nb = 0;
    req_valid = 1; req_chan = 4'd3; req_addr = 32'h5000; req_size = 2'b10;
    repeat (10) @(negedge clk);
    req_valid = 0;
    chk("R9 no beat while halted", nb, 0); chk("R9 err addr kept", err_addr, 32'h4004);
  endtask

  task automatic t_status();
    irq_mask = 0; #1;
    chk("R10 masked irq", irq, 0);
    irq_mask = 1; #1;
    chk("R10 unmasked irq", irq, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R10 flag cleared", err_flag, 0); chk("R10 irq cleared", irq, 0);
    chk("R10 still halted", halted, 1);
  endtask

  task automatic t_release();
    @(negedge clk); reset_cmd = 1; @(negedge clk); reset_cmd = 0;
    chk("R9 released", halted, 0); chk("R9 ready again", req_ready, 1);
    run_txn(4'd3, 32'h6000, 2'b10, 1, 32'h1, 4);
    chk("R9 beat after release", lg_addr[0], 32'h6000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_big();
    t_true_le();
    t_munged();
    t_burst();
    t_backpressure();
    t_error();
    t_halted_ignores();
    t_status();
    t_release();
    finish_run();
  end
endmodule